// File: doc/BRIEF.md
# Selectable-Width Cycle Tally

This block is the cycle-counting element of a performance monitoring unit. It counts processor clocks, either on every clock or once per 64 clocks through a prescaler. A long-count control input picks whether the value behaves as a 64-bit or a 32-bit counter. When the counter wraps past its selected top bit, it raises a one-cycle overflow pulse. A separate status block latches that pulse into the overflow bit reserved for the cycle counter, which is bit 31.

Software preloads the count through a write port. Preloading near the wrap point is the usual way to make the block interrupt after a chosen number of cycles. The block also outputs the remaining distance to overflow, which is the two's-complement negation of the count, kept to 32 bits in short mode.

The run control is decoded each cycle into one of three modes:
- RM_HALT: one of the two enables is low. Nothing advances.
- RM_EVERY: both enables are high and the divider select is low. The count advances on every clock.
- RM_DIV: both enables are high and the divider select is high. The prescaler phase advances on every clock, and the count advances when the phase completes a cycle of 64.

The mode changes whenever its inputs change. No transition waits on anything.

Top module: `cyc_tally`

## Requirements
- R1: While reset is asserted, the count, the remaining distance and the overflow pulse are all zero. They also read zero on the first cycle after reset is released.
- R2: With both enables high, the divider select low and no write, the count rises by one after every clock edge.
- R3: If either enable is low and there is no write, the count holds its value.
- R4: With the divider select high, the count advances once for every 64 clocks during which both enables are high. The prescaler phase holds while the counter is halted.
- R5: A write loads the count at the next edge and takes priority over an increment in the same cycle. It also resets the prescaler phase to zero. In short mode, the upper 32 bits of the written data are discarded.
- R6: In long mode, an increment from all ones produces zero and sets the overflow pulse in the same cycle that the new count appears. The wrap is the fall of bit 63.
- R7: In short mode, an increment from 0xFFFF_FFFF produces zero and sets the overflow pulse. The wrap is the fall of bit 31.
- R8: The overflow pulse lasts exactly one cycle per wrap. A write never produces an overflow pulse.
- R9: In short mode, every increment leaves bits 63:32 of the count at zero. This includes the first increment after a switch from long mode with upper bits set.
- R10: The remaining-distance output equals the negation of the count modulo 2^64 in long mode. In short mode it equals the negation of the lower 32 bits modulo 2^32, with the upper 32 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Unit-wide counting enable |
| cnt_en | input | 1 | Enable for this counter |
| div_sel | input | 1 | 1: advance once per 64 clocks |
| long_sel | input | 1 | 1: 64-bit wrap at bit 63; 0: 32-bit wrap at bit 31 |
| wr_en | input | 1 | Load the count from wr_data |
| wr_data | input | 64 | Value to load |
| count_o | output | 64 | Current count |
| remain_o | output | 64 | Increments left until overflow |
| ovf_pulse_o | output | 1 | One-cycle wrap indication |

## Verification
Counting up from zero would take 2^32 or 2^64 clocks to reach a wrap, so that is not possible. The stimulus instead preloads the count just below the wrap point through the write port.

The hardest case is a wrap in divided mode. It needs the prescaler phase at a known value. The bench gets this by writing the count while the divider is already selected, which zeroes the phase. It then runs exactly 63 enabled clocks to confirm there is no change, followed by the 64th clock that wraps.

A second hard case is a switch from long to short mode with the upper half nonzero. The bench reaches it by loading in long mode while the counter is halted, then enabling in short mode.

// File: rtl/cyc_tally_pkg.sv
package cyc_tally_pkg;
    typedef enum logic [1:0] {
        RM_HALT  = 2'd0,
        RM_EVERY = 2'd1,
        RM_DIV   = 2'd2
    } run_mode_e;
endpackage

// File: rtl/cyc_tally_ctrl.sv
module cyc_tally_ctrl
    import cyc_tally_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic glob_en,
    input  logic cnt_en,
    input  logic div_sel,
    input  logic wr_en,
    output logic tick
);
    localparam int PH_W = DIV_LOG2;

    run_mode_e          mode;
    logic [PH_W-1:0]    phase_q;

    // Mode decode: both enables gate the count, div_sel picks the rate
    always_comb begin
        unique case ({glob_en & cnt_en, div_sel})
            2'b10:   mode = RM_EVERY;
            2'b11:   mode = RM_DIV;
            default: mode = RM_HALT;
        endcase
    end

    // Prescaler phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (wr_en) begin
            phase_q <= '0;
        end else if (mode == RM_DIV) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Tick output per mode
    always_comb begin
        unique case (mode)
            RM_HALT:  tick = 1'b0;
            RM_EVERY: tick = 1'b1;
            RM_DIV:   tick = (phase_q == '1);
            default:  tick = 1'b0;
        endcase
    end

    // R4: after a divided tick the phase restarts, so no divided tick follows at once
    p_div_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == RM_DIV) |=> !(tick && div_sel));

    // R3: halted mode never ticks
    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(glob_en && cnt_en) |-> !tick);
endmodule

// File: rtl/cyc_tally_core.sv
module cyc_tally_core #(
    parameter int CW = 64,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          long_sel,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_q
);
    localparam int HW = CW - SW;

    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] inc_long;
    logic [SW-1:0] inc_short;
    logic          wrap;

    assign inc_long  = cnt_q + 1'b1;
    assign inc_short = cnt_q[SW-1:0] + 1'b1;

    always_comb begin
        cnt_nxt = cnt_q;
        wrap    = 1'b0;
        if (wr_en) begin
            cnt_nxt = long_sel ? wr_data : {{HW{1'b0}}, wr_data[SW-1:0]};
        end else if (tick) begin
            if (long_sel) begin
                cnt_nxt = inc_long;
                wrap    = cnt_q[CW-1] & ~inc_long[CW-1];
            end else begin
                cnt_nxt = {{HW{1'b0}}, inc_short};
                wrap    = cnt_q[SW-1] & ~inc_short[SW-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            ovf_q <= wrap;
        end
    end

    p_ovf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);

    p_write_no_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ovf_q);

    p_ovf_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q[SW-1:0] == '0));

    p_short_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_sel && (wr_en || tick)) |=> (cnt_q[CW-1:SW] == '0));

    p_write_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && long_sel) |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/cyc_tally.sv
module cyc_tally #(
    parameter int CW       = 64,
    parameter int SW       = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glob_en,
    input  logic          cnt_en,
    input  logic          div_sel,
    input  logic          long_sel,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] remain_o,
    output logic          ovf_pulse_o
);
    localparam int HW = CW - SW;

    logic          tick;
    logic [CW-1:0] neg;

    cyc_tally_ctrl #(.DIV_LOG2(DIV_LOG2)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .glob_en (glob_en),
        .cnt_en  (cnt_en),
        .div_sel (div_sel),
        .wr_en   (wr_en),
        .tick    (tick)
    );

    cyc_tally_core #(.CW(CW), .SW(SW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .long_sel (long_sel),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cnt_q    (count_o),
        .ovf_q    (ovf_pulse_o)
    );

    assign neg      = '0 - count_o;
    assign remain_o = long_sel ? neg : {{HW{1'b0}}, neg[SW-1:0]};

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(glob_en && cnt_en) && !wr_en) |=> $stable(count_o));

    p_every_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && cnt_en && !div_sel && !wr_en && long_sel)
        |=> (count_o == $past(count_o) + 1'b1));
endmodule

// File: tb/cyc_tally_test.sv
`timescale 1ns/1ps
module cyc_tally_test;
    typedef struct packed {
        logic [23:0] tg;
        logic        wr;
        logic        lng;
        logic        dv;
        logic        g;
        logic        c;
        logic [63:0] wd;
        logic [63:0] ec;
        logic        eo;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{"R5 ", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFD, 64'h0000_0000_FFFF_FFFD, 1'b0},
        '{"R2 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0000_0000_FFFF_FFFE, 1'b0},
        '{"R2 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b0},
        '{"R7 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 1'b1},
        '{"R8 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h1, 1'b0},
        '{"R3 ", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 64'h1, 1'b0},
        '{"R3 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 64'h1, 1'b0},
        '{"R5 ", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0},
        '{"R6 ", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{"R6 ", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 1'b1},
        '{"R8 ", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 64'h1, 1'b0},
        '{"R5 ", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'hABCD_0000_1234_5678, 64'h0000_0000_1234_5678, 1'b0},
        '{"R9 ", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0005_FFFF_FFFE, 64'h0000_0005_FFFF_FFFE, 1'b0},
        '{"R9 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0000_0000_FFFF_FFFF, 1'b0},
        '{"R7 ", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 1'b1},
        '{"R5 ", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
        '{"R8 ", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glob_en = 1'b0, cnt_en = 1'b0, div_sel = 1'b0, long_sel = 1'b0, wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] count_o, remain_o;
    logic        ovf_pulse_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cyc_tally uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_en(cnt_en),
        .div_sel(div_sel), .long_sel(long_sel), .wr_en(wr_en), .wr_data(wr_data),
        .count_o(count_o), .remain_o(remain_o), .ovf_pulse_o(ovf_pulse_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_rem(input logic [63:0] c, input logic l);
        logic [63:0] n;
        n = 64'h0 - c;
        return l ? n : {32'h0, n[31:0]};
    endfunction

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic w, input logic l, input logic d, input logic g,
                        input logic c, input logic [63:0] wd);
        wr_en = w; long_sel = l; div_sel = d; glob_en = g; cnt_en = c; wr_data = wd;
        @(negedge clk);
    endtask

    task automatic run(input int n, input logic l, input logic d);
        for (int i = 0; i < n; i++) step(1'b0, l, d, 1'b1, 1'b1, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", count_o, 64'h0);
        chk("R1 reset ovf", {63'h0, ovf_pulse_o}, 64'h0);
        chk("R1 reset remain", remain_o, 64'h0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0);
        chk("R1 after release", count_o, 64'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].lng, VEC[i].dv, VEC[i].g, VEC[i].c, VEC[i].wd);
            chk($sformatf("%s count step %0d", VEC[i].tg, i), count_o, VEC[i].ec);
            chk($sformatf("%s ovf step %0d", VEC[i].tg, i), {63'h0, ovf_pulse_o}, {63'h0, VEC[i].eo});
            chk($sformatf("R10 remain step %0d", i), remain_o, exp_rem(VEC[i].ec, VEC[i].lng));
        end

        // R4: divided counting, phase cleared by the write
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0);
        run(63, 1'b0, 1'b1);
        chk("R4 no advance after 63", count_o, 64'h0);
        run(1, 1'b0, 1'b1);
        chk("R4 advance on 64th", count_o, 64'h1);
        run(30, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h0);
        run(33, 1'b0, 1'b1);
        chk("R4 phase held while halted", count_o, 64'h1);
        run(1, 1'b0, 1'b1);
        chk("R4 second advance", count_o, 64'h2);

        // R7 in divided mode
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0000_0000_FFFF_FFFF);
        run(63, 1'b0, 1'b1);
        chk("R7 div pre-wrap count", count_o, 64'h0000_0000_FFFF_FFFF);
        chk("R7 div pre-wrap ovf", {63'h0, ovf_pulse_o}, 64'h0);
        run(1, 1'b0, 1'b1);
        chk("R7 div wrap count", count_o, 64'h0);
        chk("R7 div wrap ovf", {63'h0, ovf_pulse_o}, 64'h1);
        run(1, 1'b0, 1'b1);
        chk("R8 div pulse single", {63'h0, ovf_pulse_o}, 64'h0);

        // R1 mid-run reset
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h1234);
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0);
        chk("R1 mid-run reset", count_o, 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule